// File: doc/BRIEF.md
# Triggered Switch Control Register File

This block is the register file behind a serial control port for a multi-throw RF switch. A front-end serial decoder hands it one decoded request per cycle: an address, a read/write flag, a data byte and, for writes to the slave-ID register, the product and manufacturer identifiers carried in the same sequence. The block answers reads on a registered read-data output. It also drives three outputs to the switch core: the active 7-bit switch code, the power mode and the current slave ID.

A write to the switch register always lands in a shadow copy. The shadow is copied to the active code at once when every trigger is masked off. Otherwise it waits until a trigger bit is written as 1 while its mask bit is 0. The block keeps sticky status flags for framing errors reported by the decoder and for accesses to unused addresses. Reading the status register clears those flags. Writing 1 to its top bit performs a software reset. In low-power mode the switch outputs are held in the all-off code, and the programmed code comes back when the mode changes again.

Top module: `swreg_file`

## Requirements
- R1: After reset: swState = 0, pwrMode = 2'b10, usid = 4'hB. Address 0x1C reads 0x80, address 0x1B reads 0x00 and address 0x1A reads 0x00.
- R2: Address 0x1D reads 0x06. Address 0x1E reads 0xB0. Address 0x1F reads {2'b00, 2'b01, usid}.
- R3: With the trigger mask (0x1C bits 5:3) at 3'b111, a write to address 0x00 drives data bits 6:0 onto swState one cycle later. Reading 0x00 returns {1'b0, written bits 6:0}.
- R4: With any mask bit at 0, a write to 0x00 leaves swState unchanged. A later write to 0x1C with trigger field t (bits 2:0) and mask field m (bits 5:3) copies the held code to swState exactly when (t & ~m) != 0.
- R5: Address 0x1C reads {power mode, mask, 3'b000}, so trigger bits always read 0.
- R6: Power mode 0x1C bits 7:6 = 2'b10 forces swState to 0 and leaves the register contents intact. Any other mode drives the held active code again.
- R7: Error strobes set status bits as follows: errEvt[4] sets bit 6, errEvt[3] sets bit 5, errEvt[2] sets bit 4, errEvt[1] sets bit 3 and errEvt[0] sets bit 0. A status read (0x1A) returns the flags and then clears bits 6:0. A strobe in the same cycle as that read survives the clear.
- R8: Used addresses are 0x00 and 0x1A to 0x1F. A read of any other address returns 0x00 and sets status bit 2. A write to any other address changes nothing and sets status bit 1.
- R9: Writing 0x1A with bit 7 = 1 restores the shadow code, the active code, the group ID, the power mode and the mask to their reset values, and clears all status flags. usid keeps its value.
- R10: A write to 0x1F loads usid from data bits 3:0 only if reqKeyProd = 0x06 and reqKeyMfr = 10'h1B0. Otherwise usid is unchanged.
- R11: Address 0x1B stores data bits 3:0 as the group ID. Its bits 7:4 read as 0.
- R12: Writes to 0x1D and 0x1E change no register and set no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Decoded request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 5 | Register address |
| reqWdata | input | 8 | Write data |
| reqKeyProd | input | 8 | Product ID carried by the write sequence |
| reqKeyMfr | input | 10 | Manufacturer ID carried by the write sequence |
| errEvt | input | 5 | Framing error strobes from the decoder |
| rdData | output | 8 | Read data, registered one cycle after the read |
| swState | output | 7 | Active switch code sent to the switch core |
| pwrMode | output | 2 | Current power mode |
| usid | output | 4 | Current unique slave ID |

## Verification
The assertions assume that the decoder presents at most one request per cycle and that the request fields are stable and meaningful whenever reqValid is high. They also assume that error strobes are single-cycle pulses that may arrive at any time, including in the same cycle as a request. The stimulus issues one request at a time with an idle cycle between requests, and it changes inputs only on the falling clock edge. Error strobes are pulsed both on their own and together with a status read, so that the set-over-clear ordering is covered.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int SW_W   = 7;
  localparam int TRIG_W = 3;
  localparam int ID_W   = 4;
  localparam int ERR_W  = 5;
  localparam int STAT_W = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_SW   = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h1A;
  localparam logic [ADDR_W-1:0] A_GID  = 5'h1B;
  localparam logic [ADDR_W-1:0] A_PM   = 5'h1C;
  localparam logic [ADDR_W-1:0] A_PID  = 5'h1D;
  localparam logic [ADDR_W-1:0] A_MID  = 5'h1E;
  localparam logic [ADDR_W-1:0] A_USID = 5'h1F;

  localparam logic [7:0]      PROD_ID   = 8'h06;
  localparam logic [9:0]      MFR_ID    = 10'h1B0;
  localparam logic [ID_W-1:0] USID_INIT = 4'hB;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'b00,
    PM_STARTUP = 2'b01,
    PM_LOWPWR  = 2'b10,
    PM_RSVD    = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic wrSw;
    logic wrGid;
    logic wrPm;
    logic wrUsid;
    logic swReset;
    logic fire;
    logic rdEn;
    logic rdStatus;
    logic rdUnused;
    logic wrUnused;
  } strobe_t;
endpackage

// File: rtl/swreg_ctrl.sv
module swreg_ctrl
  import swreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [7:0]        reqKeyProd,
  input  logic [9:0]        reqKeyMfr,
  output strobe_t           st
);
  logic isWr, isRd, usedAddr, keyOk;
  logic [TRIG_W-1:0] newMask, newTrig;
  logic unusedBit;

  assign unusedBit = reqWdata[6];
  assign isWr      = reqValid && reqWrite;
  assign isRd      = reqValid && !reqWrite;
  assign usedAddr  = (reqAddr == A_SW) || (reqAddr >= A_STAT);
  assign keyOk     = (reqKeyProd == PROD_ID) && (reqKeyMfr == MFR_ID);
  assign newMask   = reqWdata[2*TRIG_W-1:TRIG_W];
  assign newTrig   = reqWdata[TRIG_W-1:0];

  always_comb begin
    st          = '0;
    st.wrSw     = isWr && (reqAddr == A_SW);
    st.wrGid    = isWr && (reqAddr == A_GID);
    st.wrPm     = isWr && (reqAddr == A_PM);
    st.wrUsid   = isWr && (reqAddr == A_USID) && keyOk;
    st.swReset  = isWr && (reqAddr == A_STAT) && reqWdata[DATA_W-1];
    st.fire     = st.wrPm && ((newTrig & ~newMask) != '0);
    st.rdEn     = isRd;
    st.rdStatus = isRd && (reqAddr == A_STAT);
    st.rdUnused = isRd && !usedAddr;
    st.wrUnused = isWr && !usedAddr;
  end

  // R8 R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrSw, st.wrGid, st.wrPm, st.wrUsid, st.swReset, st.wrUnused,
              st.rdEn}));
endmodule

// File: rtl/swreg_dp.sv
module swreg_dp
  import swreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ERR_W-1:0]  errEvt,
  output logic [DATA_W-1:0] rdData,
  output logic [SW_W-1:0]   swState,
  output logic [1:0]        pwrMode,
  output logic [ID_W-1:0]   usid
);
  logic [SW_W-1:0]   shadowSw, activeSw;
  logic [ID_W-1:0]   gid, usidReg;
  logic [TRIG_W-1:0] mask;
  pwr_mode_e         pm;
  logic [STAT_W-1:0] statusReg, statusNext;
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSw <= '0;
      activeSw <= '0;
      gid      <= '0;
      pm       <= PM_LOWPWR;
      mask     <= '0;
      usidReg  <= USID_INIT;
    end else if (st.swReset) begin
      shadowSw <= '0;
      activeSw <= '0;
      gid      <= '0;
      pm       <= PM_LOWPWR;
      mask     <= '0;
    end else begin
      if (st.wrSw) shadowSw <= reqWdata[SW_W-1:0];
      if (st.wrSw && (&mask)) activeSw <= reqWdata[SW_W-1:0];
      if (st.fire) activeSw <= shadowSw;
      if (st.wrGid) gid <= reqWdata[ID_W-1:0];
      if (st.wrPm) begin
        pm   <= pwr_mode_e'(reqWdata[DATA_W-1:DATA_W-2]);
        mask <= reqWdata[2*TRIG_W-1:TRIG_W];
      end
      if (st.wrUsid) usidReg <= reqWdata[ID_W-1:0];
    end
  end

  always_comb begin
    statusNext      = st.rdStatus ? '0 : statusReg;
    statusNext[6:3] = statusNext[6:3] | errEvt[4:1];
    statusNext[0]   = statusNext[0] | errEvt[0];
    statusNext[2]   = statusNext[2] | st.rdUnused;
    statusNext[1]   = statusNext[1] | st.wrUnused;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           statusReg <= '0;
    else if (st.swReset) statusReg <= '0;
    else                 statusReg <= statusNext;
  end

  always_comb begin
    case (reqAddr)
      A_SW:    rdMux = {1'b0, shadowSw};
      A_STAT:  rdMux = {1'b0, statusReg};
      A_GID:   rdMux = {{(DATA_W-ID_W){1'b0}}, gid};
      A_PM:    rdMux = {pm, mask, {TRIG_W{1'b0}}};
      A_PID:   rdMux = PROD_ID;
      A_MID:   rdMux = MFR_ID[7:0];
      A_USID:  rdMux = {2'b00, MFR_ID[9:8], usidReg};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (st.rdEn) rdData <= rdMux;
  end

  assign swState = (pm == PM_LOWPWR) ? '0 : activeSw;
  assign pwrMode = pm;
  assign usid    = usidReg;

  // R9
  swreset_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.swReset |=> (pwrMode == 2'b10 && swState == '0 && statusReg == '0 && mask == '0));

  // R8
  unused_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrUnused || st.rdUnused) |=> (statusReg[1] || statusReg[2]));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.fire && !st.swReset && !(st.wrSw && (&mask))) |=> $stable(activeSw));

  // R5
  trig_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && reqAddr == A_PM) |=> (rdData[TRIG_W-1:0] == '0));
endmodule

// File: rtl/swreg_file.sv
module swreg_file
  import swreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [4:0]  reqAddr,
  input  logic [7:0]  reqWdata,
  input  logic [7:0]  reqKeyProd,
  input  logic [9:0]  reqKeyMfr,
  input  logic [4:0]  errEvt,
  output logic [7:0]  rdData,
  output logic [6:0]  swState,
  output logic [1:0]  pwrMode,
  output logic [3:0]  usid
);
  strobe_t st;

  swreg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqKeyProd(reqKeyProd),
    .reqKeyMfr(reqKeyMfr), .st(st)
  );

  swreg_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .errEvt(errEvt), .rdData(rdData), .swState(swState), .pwrMode(pwrMode),
    .usid(usid)
  );

  // R10
  usid_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr == 5'h1F &&
     (reqKeyProd != 8'h06 || reqKeyMfr != 10'h1B0)) |=> $stable(usid));
endmodule

// File: tb/tb_swreg_file.sv
module tb_swreg_file;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0] reqAddr = '0;
  logic [7:0] reqWdata = '0, reqKeyProd = '0;
  logic [9:0] reqKeyMfr = '0;
  logic [4:0] errEvt = '0;
  logic [7:0] rdData;
  logic [6:0] swState;
  logic [1:0] pwrMode;
  logic [3:0] usid;

  int nTests = 0, nFail = 0;
  logic [7:0] v;

  swreg_file dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk); reqValid = 0; reqWrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] val);
    @(negedge clk); reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk); reqValid = 0; val = rdData;
  endtask

  task automatic pulseErr(input logic [4:0] e);
    @(negedge clk); errEvt = e;
    @(negedge clk); errEvt = '0;
  endtask

  function automatic logic isUsed(input int a);
    return (a == 0) || (a >= 26);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 swState", swState, 0);
    chk("R1 pwrMode", pwrMode, 2);
    chk("R1 usid", usid, 4'hB);
    rd(5'h1C, v); chk("R1 rd 1C", v, 8'h80);
    rd(5'h1B, v); chk("R1 rd 1B", v, 8'h00);
    rd(5'h1A, v); chk("R1 rd 1A", v, 8'h00);
    // R2 identifiers
    rd(5'h1D, v); chk("R2 product", v, 8'h06);
    rd(5'h1E, v); chk("R2 mfr low", v, 8'hB0);
    rd(5'h1F, v); chk("R2 mfr hi/usid", v, 8'h1B);
    // R8 address sweep
    for (int a = 0; a < 32; a++) begin
      if (!isUsed(a)) begin
        rd(a[4:0], v); chk("R8 unused rd", v, 0);
        rd(5'h1A, v); chk("R8 rd flag", v, 8'h04);
        rd(5'h1A, v); chk("R7 clear", v, 8'h00);
      end
    end
    wr(5'h05, 8'hFF);
    rd(5'h1A, v); chk("R8 wr flag", v, 8'h02);
    // R3 immediate apply, all codes
    wr(5'h1C, 8'b00_111_000);
    for (int c = 0; c < 128; c++) begin
      wr(5'h00, 8'h80 | c[7:0]);
      chk("R3 swState", swState, c);
      rd(5'h00, v); chk("R3 readback", v, c);
    end
    // R4 R5 trigger/mask sweep
    for (int m = 0; m < 7; m++) begin
      for (int t = 0; t < 8; t++) begin
        logic fire;
        wr(5'h1C, 8'b00_111_000);
        wr(5'h00, 8'h15);
        wr(5'h1C, {2'b00, m[2:0], 3'b000});
        wr(5'h00, 8'h6A);
        chk("R4 held", swState, 7'h15);
        wr(5'h1C, {2'b00, m[2:0], t[2:0]});
        fire = (t[2:0] & ~m[2:0]) != 0;
        chk("R4 trigger", swState, fire ? 7'h6A : 7'h15);
        rd(5'h1C, v); chk("R5 rd 1C", v, {2'b00, m[2:0], 3'b000});
      end
    end
    // R6 power modes
    wr(5'h1C, 8'b00_111_000);
    wr(5'h00, 8'h33);
    wr(5'h1C, 8'b10_111_000);
    chk("R6 lowpwr sw", swState, 0);
    chk("R6 lowpwr mode", pwrMode, 2);
    rd(5'h00, v); chk("R6 reg kept", v, 8'h33);
    wr(5'h1C, 8'b00_111_000);
    chk("R6 restore", swState, 7'h33);
    wr(5'h1C, 8'b01_111_000);
    chk("R6 startup", swState, 7'h33);
    wr(5'h1C, 8'b00_111_000);
    // R7 error bits
    for (int i = 0; i < 5; i++) begin
      logic [7:0] exp;
      exp = (i == 0) ? 8'h01 : (8'h01 << (i + 2));
      pulseErr(5'b1 << i);
      rd(5'h1A, v); chk("R7 err bit", v, exp);
      rd(5'h1A, v); chk("R7 cleared", v, 0);
    end
    pulseErr(5'b00010);
    @(negedge clk); reqValid = 1; reqWrite = 0; reqAddr = 5'h1A; errEvt = 5'b00001;
    @(negedge clk); reqValid = 0; errEvt = 0; v = rdData;
    chk("R7 old value", v, 8'h08);
    rd(5'h1A, v); chk("R7 set wins", v, 8'h01);
    // R11 group ID
    wr(5'h1B, 8'hFF);
    rd(5'h1B, v); chk("R11 gid", v, 8'h0F);
    // R12 read-only addresses
    wr(5'h1D, 8'h55); wr(5'h1E, 8'h55);
    rd(5'h1D, v); chk("R12 pid", v, 8'h06);
    rd(5'h1E, v); chk("R12 mid", v, 8'hB0);
    rd(5'h1A, v); chk("R12 no flag", v, 0);
    // R10 USID programming
    reqKeyProd = 8'h07; reqKeyMfr = 10'h1B0;
    wr(5'h1F, 8'h05); chk("R10 bad prod", usid, 4'hB);
    reqKeyProd = 8'h06; reqKeyMfr = 10'h1B1;
    wr(5'h1F, 8'h05); chk("R10 bad mfr", usid, 4'hB);
    reqKeyMfr = 10'h1B0;
    wr(5'h1F, 8'h05); chk("R10 match", usid, 4'h5);
    rd(5'h1F, v); chk("R10 rd", v, 8'h15);
    // R9 software reset
    wr(5'h1B, 8'h03);
    wr(5'h00, 8'h44);
    pulseErr(5'b10000);
    wr(5'h1A, 8'h80);
    chk("R9 swState", swState, 0);
    chk("R9 pwrMode", pwrMode, 2);
    chk("R9 usid kept", usid, 4'h5);
    rd(5'h1C, v); chk("R9 rd 1C", v, 8'h80);
    rd(5'h1B, v); chk("R9 rd 1B", v, 0);
    rd(5'h1A, v); chk("R9 rd 1A", v, 0);
    rd(5'h00, v); chk("R9 rd 00", v, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule